// File: doc/BRIEF.md
# Host-to-PCI Address Window Decoder

This block sits between a 32-bit processor bus and a simple PCI host bridge. For each outbound request it decides which bridge window the CPU address falls in and produces the PCI-side address: a configuration address built from a one-hot device-select field, an I/O port address under a run-time selectable contiguous or sparse mapping, a memory-window offset, or the byte-wide interrupt-acknowledge location. Addresses outside every window give a no-decode code with a zero address.

A second, independent path maps inbound bus-master addresses from PCI devices. The upper half of the 4 GB space lands on system RAM from address 0, and the low part reflects back onto the PCI memory window. Both paths are combinational. An optional register stage, enabled by default, adds one cycle of latency, and a valid bit travels with each result.

Top module: `pci_win_decode`

## Requirements
- R1: A request with address in [0x8080_0000, 0x80BF_FFFF] gives region code 1 (config). Address bits 10:8 appear on `cfg_func`, bits 7:0 on `cfg_reg`, and `cfg_bus` is 0.
- R2: For a config request, the device number is the index k (0..10) of the lowest set bit among address bits 11..21 (bit 11+k), or 11 when none is set. It appears on `cfg_dev`. `out_addr` equals (address & 0x7FF) | (device << 11).
- R3: A request in [0x8000_0000, 0x807F_FFFF] with `io_sparse` low gives an I/O region and `out_addr` = offset mod 65536, where the offset is the address minus 0x8000_0000.
- R4: With `io_sparse` high, the I/O address is offset[4:0] + 32 * offset[22:12]. Every 4 KB CPU page therefore gives 32 port bytes.
- R5: `io_sparse` is a level input. Each request uses the level present with that request, and the mode may change between back-to-back requests.
- R6: A request in [0xC000_0000, 0xFEFF_FFFF] gives region code 5 (memory) and `out_addr` = address minus 0xC000_0000.
- R7: A single-byte read (`req_size`=1, `req_write`=0) of exactly 0xBFFF_FFF0 gives region code 6 (interrupt acknowledge) with address 0. A write, or any other size, there gives region code 0.
- R8: An I/O request whose translated port address is 0xCF8 gives region code 3, and one whose translated address is 0xCFC gives region code 4. Any other I/O port gives region code 2.
- R9: Any valid request outside all windows gives region code 0 with `out_addr`, `cfg_dev`, `cfg_func` and `cfg_reg` all 0.
- R10: An inbound address at or above 0x8000_0000 gives `bm_out_tgt` 1 (RAM) with `bm_out_addr` = address minus 0x8000_0000.
- R11: An inbound address below 0x3F00_0000 gives `bm_out_tgt` 2 (PCI memory) with the address unchanged. An inbound address in [0x3F00_0000, 0x7FFF_FFFF] gives target 0 and address 0.
- R12: With the output stage enabled, results appear one clock after the request along with `out_valid`/`bm_out_valid`. An invalid request gives valid low and region code 0. Reset clears both valids and the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Outbound request present |
| req_addr | input | 32 | CPU-side address |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | Request is a write |
| io_sparse | input | 1 | High selects the sparse I/O mapping |
| bm_valid | input | 1 | Inbound bus-master address present |
| bm_addr | input | 32 | Inbound bus-master address |
| out_valid | output | 1 | Outbound result valid |
| out_region | output | 3 | Region code (0 none, 1 config, 2 I/O, 3 config index port, 4 config data port, 5 memory, 6 interrupt ack) |
| out_addr | output | 32 | Translated PCI-side address |
| cfg_bus | output | 8 | Config bus number (always 0) |
| cfg_dev | output | 5 | Config device number |
| cfg_func | output | 3 | Config function number |
| cfg_reg | output | 8 | Config register byte offset |
| bm_out_valid | output | 1 | Inbound result valid |
| bm_out_tgt | output | 2 | Inbound target (0 none, 1 RAM, 2 PCI memory) |
| bm_out_addr | output | 32 | Translated inbound address |

## Verification
The hardest case to reach is a configuration-port hit under the sparse mapping. The CPU offset that lands on port 0xCF8 has the port's high bits moved up into the page field, at 0x67018, and the contiguous alias 0x10CF8 must also flag. The bench computes those offsets from the mapping formula and drives them in both modes. It also toggles the mode between back-to-back requests to the same address, so that a stale mode would be visible. Every window edge is probed on both sides, and the config scan is swept over each device-select bit with higher bits also set.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
    localparam logic [31:0] IO_BASE    = 32'h8000_0000;
    localparam logic [31:0] IO_SPAN    = 32'h0080_0000;
    localparam logic [31:0] CFG_BASE   = 32'h8080_0000;
    localparam logic [31:0] CFG_SPAN   = 32'h0040_0000;
    localparam logic [31:0] MEM_BASE   = 32'hC000_0000;
    localparam logic [31:0] MEM_SPAN   = 32'h3F00_0000;
    localparam logic [31:0] IACK_ADDR  = 32'hBFFF_FFF0;
    localparam logic [31:0] BM_RAM_BASE = 32'h8000_0000;
    localparam logic [31:0] PORT_CIDX  = 32'h0000_0CF8;
    localparam logic [31:0] PORT_CDATA = 32'h0000_0CFC;
    localparam int          SEL_LSB    = 11;
    localparam int          SEL_COUNT  = 11;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0, RG_CFG = 3'd1, RG_IO = 3'd2, RG_IO_CIDX = 3'd3,
        RG_IO_CDATA = 3'd4, RG_MEM = 3'd5, RG_IACK = 3'd6
    } region_e;

    typedef enum logic [1:0] {
        BT_NONE = 2'd0, BT_RAM = 2'd1, BT_PCIMEM = 2'd2
    } bm_tgt_e;

    typedef struct packed {
        logic        valid;
        region_e     region;
        logic [31:0] addr;
        logic [4:0]  dev;
        logic [2:0]  func;
        logic [7:0]  regno;
    } out_s;

    typedef struct packed {
        logic        valid;
        bm_tgt_e     tgt;
        logic [31:0] addr;
    } bm_s;

    function automatic logic in_win(logic [31:0] a, logic [31:0] base, logic [31:0] span);
        logic [32:0] lo, hi;
        lo = {1'b0, base};
        hi = {1'b0, base} + {1'b0, span};
        return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
    endfunction
endpackage

// File: rtl/pwd_cfg_xlate.sv
module pwd_cfg_xlate #(
    parameter int LSB  = 11,
    parameter int NSEL = 11
) (
    input  logic [LSB+NSEL-1:0] addr,
    output logic [4:0]          dev,
    output logic [31:0]         cfg_addr
);
    localparam logic [31:0] LOW_MASK = (32'd1 << LSB) - 32'd1;

    always_comb begin
        dev = 5'(NSEL);
        for (int i = NSEL - 1; i >= 0; i--) begin
            if (addr[LSB+i]) dev = 5'(i);
        end
        cfg_addr = (32'(addr) & LOW_MASK) | (32'(dev) << LSB);
    end
endmodule

// File: rtl/pwd_io_xlate.sv
module pwd_io_xlate #(
    parameter int PAGE_LSB = 12,
    parameter int KEEP_LO  = 5,
    parameter int OFF_W    = 23,
    parameter int CONT_W   = 16
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             sparse,
    output logic [31:0]      io_addr
);
    localparam int          SHIFT   = PAGE_LSB - KEEP_LO;
    localparam logic [31:0] LO_MASK = (32'd1 << KEEP_LO) - 32'd1;
    localparam logic [31:0] PG_MASK = ((32'd1 << OFF_W) - 32'd1) & ~((32'd1 << PAGE_LSB) - 32'd1);
    localparam logic [31:0] CT_MASK = (32'd1 << CONT_W) - 32'd1;

    logic [31:0] off_w;
    assign off_w = 32'(offset);

    always_comb begin
        if (sparse) io_addr = (off_w & LO_MASK) | ((off_w & PG_MASK) >> SHIFT);
        else        io_addr = off_w & CT_MASK;
    end
endmodule

// File: rtl/pwd_bm_xlate.sv
module pwd_bm_xlate
    import pwd_pkg::*;
(
    input  logic [31:0] addr,
    output bm_tgt_e     tgt,
    output logic [31:0] xaddr
);
    always_comb begin
        if (addr >= BM_RAM_BASE) begin
            tgt   = BT_RAM;
            xaddr = addr - BM_RAM_BASE;
        end else if (addr < MEM_SPAN) begin
            tgt   = BT_PCIMEM;
            xaddr = addr;
        end else begin
            tgt   = BT_NONE;
            xaddr = '0;
        end
    end
endmodule

// File: rtl/pci_win_decode.sv
module pci_win_decode
    import pwd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [2:0]  req_size,
    input  logic        req_write,
    input  logic        io_sparse,
    input  logic        bm_valid,
    input  logic [31:0] bm_addr,
    output logic        out_valid,
    output logic [2:0]  out_region,
    output logic [31:0] out_addr,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_func,
    output logic [7:0]  cfg_reg,
    output logic        bm_out_valid,
    output logic [1:0]  bm_out_tgt,
    output logic [31:0] bm_out_addr
);
    localparam int IO_OFF_W = $clog2(IO_SPAN);

    logic [4:0]  sel_dev;
    logic [31:0] sel_addr;
    logic [31:0] io_off;
    logic [31:0] io_port;
    bm_tgt_e     bm_tgt;
    logic [31:0] bm_x;
    out_s        d, q;
    bm_s         db, qb;

    assign io_off = req_addr - IO_BASE;

    pwd_cfg_xlate #(.LSB(SEL_LSB), .NSEL(SEL_COUNT)) u_cfg (
        .addr     (req_addr[SEL_LSB+SEL_COUNT-1:0]),
        .dev      (sel_dev),
        .cfg_addr (sel_addr)
    );

    pwd_io_xlate #(.OFF_W(IO_OFF_W)) u_io (
        .offset  (io_off[IO_OFF_W-1:0]),
        .sparse  (io_sparse),
        .io_addr (io_port)
    );

    pwd_bm_xlate u_bm (
        .addr  (bm_addr),
        .tgt   (bm_tgt),
        .xaddr (bm_x)
    );

    always_comb begin
        d        = '0;
        d.region = RG_NONE;
        d.valid  = req_valid;
        if (req_valid) begin
            if (in_win(req_addr, CFG_BASE, CFG_SPAN)) begin
                d.region = RG_CFG;
                d.addr   = sel_addr;
                d.dev    = sel_dev;
                d.func   = req_addr[10:8];
                d.regno  = req_addr[7:0];
            end else if (in_win(req_addr, IO_BASE, IO_SPAN)) begin
                d.addr = io_port;
                if (io_port == PORT_CIDX)       d.region = RG_IO_CIDX;
                else if (io_port == PORT_CDATA) d.region = RG_IO_CDATA;
                else                            d.region = RG_IO;
            end else if (in_win(req_addr, MEM_BASE, MEM_SPAN)) begin
                d.region = RG_MEM;
                d.addr   = req_addr - MEM_BASE;
            end else if (req_addr == IACK_ADDR && req_size == 3'd1 && !req_write) begin
                d.region = RG_IACK;
            end
        end
    end

    always_comb begin
        db       = '0;
        db.tgt   = BT_NONE;
        db.valid = bm_valid;
        if (bm_valid) begin
            db.tgt  = bm_tgt;
            db.addr = bm_x;
        end
    end

    generate
        if (OUT_REG) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    q  <= '0;
                    qb <= '0;
                end else begin
                    q  <= d;
                    qb <= db;
                end
            end
        end else begin : g_bypass
            assign q  = d;
            assign qb = db;
        end
    endgenerate

    assign out_valid    = q.valid;
    assign out_region   = q.region;
    assign out_addr     = q.addr;
    assign cfg_bus      = 8'd0;
    assign cfg_dev      = q.dev;
    assign cfg_func     = q.func;
    assign cfg_reg      = q.regno;
    assign bm_out_valid = qb.valid;
    assign bm_out_tgt   = qb.tgt;
    assign bm_out_addr  = qb.addr;
endmodule

// File: rtl/pwd_chk.sv
module pwd_chk #(
    parameter bit LAT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [2:0]  req_size,
    input logic        req_write,
    input logic        io_sparse,
    input logic        out_valid,
    input logic [2:0]  out_region,
    input logic [31:0] out_addr,
    input logic [4:0]  cfg_dev,
    input logic [1:0]  bm_out_tgt,
    input logic [31:0] bm_out_addr
);
    p_none_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (out_region == 3'd0) |-> (out_addr == 32'd0));

    p_dev_range_r2: assert property (@(posedge clk) disable iff (rst)
        (out_region == 3'd1) |-> (cfg_dev <= 5'd11));

    p_ram_half_r10: assert property (@(posedge clk) disable iff (rst)
        (bm_out_tgt == 2'd1) |-> !bm_out_addr[31]);

    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_region == 3'd0));

    generate
        if (LAT) begin : g_lat
            p_valid_lat_r12: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (out_valid == $past(req_valid)));

            p_iack_byte_r7: assert property (@(posedge clk) disable iff (rst)
                (out_region == 3'd6) |-> ($past(req_size) == 3'd1 && !$past(req_write)));

            p_contig_mask_r3: assert property (@(posedge clk) disable iff (rst)
                (out_region == 3'd2 && !$past(io_sparse))
                |-> (out_addr == {16'd0, $past(req_addr[15:0])}));
        end
    endgenerate
endmodule

bind pci_win_decode pwd_chk #(.LAT(OUT_REG)) u_pwd_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .req_write   (req_write),
    .io_sparse   (io_sparse),
    .out_valid   (out_valid),
    .out_region  (out_region),
    .out_addr    (out_addr),
    .cfg_dev     (cfg_dev),
    .bm_out_tgt  (bm_out_tgt),
    .bm_out_addr (bm_out_addr)
);

// File: tb/tb_pci_win_decode.sv
module tb_pci_win_decode;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic        req_write = 1'b0;
    logic        io_sparse = 1'b0;
    logic        bm_valid = 1'b0;
    logic [31:0] bm_addr = '0;
    logic        out_valid;
    logic [2:0]  out_region;
    logic [31:0] out_addr;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [7:0]  cfg_reg;
    logic        bm_out_valid;
    logic [1:0]  bm_out_tgt;
    logic [31:0] bm_out_addr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pci_win_decode dut (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent model of the outbound decode
    task automatic model(input logic [31:0] a, input logic [2:0] sz, input logic wr, input logic sp,
                         output logic [2:0] rg, output logic [31:0] xa,
                         output logic [4:0] dv, output logic [2:0] fn, output logic [7:0] rn);
        longint unsigned ua, off, port;
        ua = a; rg = 0; xa = 0; dv = 0; fn = 0; rn = 0;
        if (ua >= 64'h8080_0000 && ua <= 64'h80BF_FFFF) begin
            rg = 1;
            dv = 11;
            for (int k = 10; k >= 0; k--) if (a[11+k]) dv = 5'(k);
            fn = 3'((ua / 256) % 8);
            rn = 8'(ua % 256);
            xa = 32'((ua % 2048) + 2048 * dv);
        end else if (ua >= 64'h8000_0000 && ua <= 64'h807F_FFFF) begin
            off = ua - 64'h8000_0000;
            if (sp) port = (off % 32) + 32 * (off / 4096);
            else    port = off % 65536;
            xa = 32'(port);
            rg = (port == 64'hCF8) ? 3 : (port == 64'hCFC) ? 4 : 2;
        end else if (ua >= 64'hC000_0000 && ua <= 64'hFEFF_FFFF) begin
            rg = 5;
            xa = 32'(ua - 64'hC000_0000);
        end else if (ua == 64'hBFFF_FFF0 && sz == 1 && !wr) begin
            rg = 6;
        end
    endtask

    task automatic send(string tag, logic [31:0] a, logic [2:0] sz, logic wr, logic sp);
        logic [2:0] rg; logic [31:0] xa; logic [4:0] dv; logic [2:0] fn; logic [7:0] rn;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_size = sz; req_write = wr; io_sparse = sp;
        model(a, sz, wr, sp, rg, xa, dv, fn, rn);
        @(negedge clk);
        chk({tag, " region"}, 64'(out_region), 64'(rg));
        chk({tag, " addr"},   64'(out_addr),   64'(xa));
        chk({tag, " tuple"},  {cfg_bus, cfg_dev, cfg_func, cfg_reg, out_valid},
                              {8'd0, dv, fn, rn, 1'b1});
    endtask

    task automatic send_bm(string tag, logic [31:0] a);
        longint unsigned ua;
        logic [1:0] et; logic [31:0] ea;
        ua = a;
        if (ua >= 64'h8000_0000)      begin et = 1; ea = 32'(ua - 64'h8000_0000); end
        else if (ua < 64'h3F00_0000)  begin et = 2; ea = a; end
        else                          begin et = 0; ea = 0; end
        @(negedge clk);
        bm_valid = 1; bm_addr = a;
        @(negedge clk);
        chk({tag, " bm"}, {bm_out_valid, bm_out_tgt, bm_out_addr}, {1'b1, et, ea});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset", {out_valid, out_region, bm_out_valid, bm_out_tgt}, '0);
        rst = 0;
        @(negedge clk);
        chk("R12 idle", {out_valid, out_region, bm_out_valid}, '0);

        // R1 R2: config scan, each select bit, with and without higher bits
        for (int k = 0; k <= 10; k++) begin
            send("R2 cfg sel", 32'h8080_0000 | (32'd1 << (11 + k)) | 32'((k * 147) % 2048), 4, 0, 0);
            send("R2 cfg multi", 32'h8080_0000 | (32'd1 << (11 + k)) | 32'h0020_0000 | 32'h5A5, 4, 1, 1);
        end
        send("R2 cfg none", 32'h8080_07FF, 1, 0, 0);
        send("R1 cfg func", 32'h8080_0634, 2, 0, 0);

        // R3 R4: I/O sweeps in both modes
        for (int i = 0; i < 48; i++) begin
            send("R3 io contig", 32'h8000_0000 + 32'((i * 32'h0002_A1F3) % 32'h0080_0000), 4, 0, 0);
            send("R4 io sparse", 32'h8000_0000 + 32'((i * 32'h0002_A1F3) % 32'h0080_0000), 4, 0, 1);
        end
        // R5: mode flips between back-to-back requests to one address
        for (int i = 0; i < 6; i++) send("R5 mode flip", 32'h8012_3456, 4, 0, 1'(i % 2));

        // R8: config port flags in both mappings
        send("R8 cidx contig", 32'h8000_0CF8, 4, 0, 0);
        send("R8 cdata contig", 32'h8000_0CFC, 4, 0, 0);
        send("R8 cidx alias", 32'h8001_0CF8, 4, 0, 0);
        send("R8 cidx sparse", 32'h8006_7018, 4, 0, 1);
        send("R8 cdata sparse", 32'h8006_701C, 4, 0, 1);
        send("R8 plain port", 32'h8000_0CF9, 1, 0, 0);

        // R6 R7 R9: window edges
        send("R9 below io", 32'h7FFF_FFFF, 4, 0, 0);
        send("R3 io first", 32'h8000_0000, 4, 0, 0);
        send("R4 io last", 32'h807F_FFFF, 1, 0, 1);
        send("R1 cfg first", 32'h8080_0000, 4, 0, 0);
        send("R1 cfg last", 32'h80BF_FFFF, 1, 0, 0);
        send("R9 after cfg", 32'h80C0_0000, 4, 0, 0);
        send("R9 below iack", 32'hBFFF_FFEF, 1, 0, 0);
        send("R7 iack read", 32'hBFFF_FFF0, 1, 0, 0);
        send("R7 iack write", 32'hBFFF_FFF0, 1, 1, 0);
        send("R7 iack size2", 32'hBFFF_FFF0, 2, 0, 0);
        send("R7 iack size4", 32'hBFFF_FFF0, 4, 0, 0);
        send("R9 above iack", 32'hBFFF_FFF1, 1, 0, 0);
        send("R9 top hole", 32'hBFFF_FFFF, 4, 0, 0);
        send("R6 mem first", 32'hC000_0000, 4, 0, 0);
        send("R6 mem mid", 32'hD234_5678, 4, 1, 0);
        send("R6 mem last", 32'hFEFF_FFFF, 1, 0, 0);
        send("R9 above mem", 32'hFF00_0000, 4, 0, 0);
        send("R9 all ones", 32'hFFFF_FFFF, 4, 0, 0);
        send("R9 zero", 32'h0000_0000, 4, 0, 0);

        // R12: invalid request gives no output
        @(negedge clk);
        req_valid = 0; req_addr = 32'hC000_0010;
        @(negedge clk);
        chk("R12 invalid", {out_valid, out_region, out_addr}, '0);

        // R10 R11: inbound mapping
        send_bm("R10 ram first", 32'h8000_0000);
        send_bm("R10 ram last", 32'hFFFF_FFFF);
        send_bm("R11 pcimem zero", 32'h0000_0000);
        send_bm("R11 pcimem last", 32'h3EFF_FFFF);
        send_bm("R11 gap first", 32'h3F00_0000);
        send_bm("R11 gap last", 32'h7FFF_FFFF);
        for (int i = 0; i < 32; i++) send_bm("R10 R11 sweep", 32'(i * 32'h0813_5A27));
        @(negedge clk);
        bm_valid = 0;
        @(negedge clk);
        chk("R12 bm invalid", {bm_out_valid, bm_out_tgt, bm_out_addr}, '0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule